// File: doc/BRIEF.md
# Remappable System Bus Address Decoder

This block sits between a 16-bit processor bus with a 24-bit byte address and the memories and peripherals behind it. On every access it asserts exactly one region select and produces the offset into the selected target. The targets are boot ROM, cartridge ROM, DRAM, an on-block 256 x 16 colour lookup table, the two memory-control words, and a catch-all for every other peripheral range. Accesses that fall into the catch-all range raise an unhandled flag.

The 16 MB space is cut into eight 2 MB windows. Each window is decoded on its own from a small map state. After reset every window shows the boot ROM, which mirrors through the window. The first write to control word 1, and any later write that flips its bit 0, picks one of two layouts. Each layout places three cartridge windows, a pair of DRAM windows, two DRAM mirror windows and one boot window. The upper half of every boot window holds the register and lookup-table range. A cartridge smaller than its windows wraps inside them. Cartridge locations past the loaded image, after the image size is rounded up to an even number of bytes, read as all ones on the block's own read data.

Top module: `sysbus_remap_decoder`

## Requirements
- R1: While reset is held and after it is released, ctrl1 and ctrl2 read 0, all lookup-table entries are 0, and every window is a boot window. Lower-half offsets select boot ROM (sel bit 0) with mem_offset = bus_addr & (BOOT_BYTES-1).
- R2: While bus_req is 1, exactly one bit of sel is 1. While bus_req is 0, sel is all zero and unhandled is 0. The sel bit positions are: 0 boot ROM, 1 cartridge, 2 DRAM, 3 lookup table, 4 control words, 5 other.
- R3: In the upper half of a boot window (window offset bit 20 = 1), let io = window offset bits 19:0. io below 0x400 selects the control words with mem_offset = io & 0x3FE. io from 0x400 to 0x7FF selects the lookup table with mem_offset = io[8:1]. Higher io selects other, with mem_offset = 0.
- R4: A write with control offset 0 stores bus_wdata into ctrl1, and a write with control offset 2 stores it into ctrl2. The new value appears on the port in the cycle after the write.
- R5: With the map active and mode bit 1, windows 0-3 are DRAM, windows 4, 5 and 6 are cartridge slots 0, 1 and 2, and window 7 is a boot window.
- R6: With the map active and mode bit 0, window 0 is a boot window, windows 1, 2 and 3 are cartridge slots 0, 1 and 2, and windows 4-7 are DRAM.
- R7: A ctrl1 write changes the map only when it is the first ctrl1 write since reset or when it flips bit 0. The map then takes bit 0 as its mode from the next cycle. The first write activates the map even when bit 0 is 0.
- R8: The cartridge offset is (slot x 0x200000 + window offset) & (CART_BYTES-1), so small cartridges mirror.
- R9: The DRAM offset is the window offset & (DRAM_BYTES-1) in every DRAM window.
- R10: A write to the lookup table stores bus_wdata at the entry given by io[8:1]. rdata shows the addressed entry in the same cycle as a lookup-table access.
- R11: A cartridge access whose offset is at or above the image size rounded up to even gives rdata = 0xFFFF. Every other access gives rdata = 0, except a lookup-table access.
- R12: unhandled is 1 on any access to other, on any read of the control words, and on a write to a control offset other than 0 or 2. Such a write leaves ctrl1, ctrl2 and the map unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 16 | Write data |
| sel | output | 6 | One-hot region select |
| mem_offset | output | 24 | Offset inside the selected target |
| rdata | output | 16 | Block's own read data (lookup table, padding) |
| unhandled | output | 1 | Access not served by this block |
| ctrl1 | output | 16 | Memory-control word 1 |
| ctrl2 | output | 16 | Memory-control word 2 |

## Verification
sel, mem_offset, rdata and unhandled are combinational from the address and the registered map. They are due in the cycle of the access itself. The ctrl words, the lookup-table contents and the map change at the clock edge that ends a write, so their effect is due on the next access. The bench drives each access just after a falling edge and compares all outputs 2 ns later against a behavioural model. It updates the model only after that comparison, so each write shows up exactly one cycle later in both the model and the design.

// File: rtl/srd_pkg.sv
package srd_pkg;
    localparam int WIN_N     = 8;
    localparam int CART_WINS = 3;
    localparam int REG_N     = 6;

    localparam int SEL_BOOT  = 0;
    localparam int SEL_CART  = 1;
    localparam int SEL_DRAM  = 2;
    localparam int SEL_LUT   = 3;
    localparam int SEL_CTRL  = 4;
    localparam int SEL_OTHER = 5;

    // first window of each block in the two layouts
    localparam int HI_CART_FIRST = 4;
    localparam int LO_CART_FIRST = 1;

    typedef enum logic [1:0] {
        WK_BOOT = 2'd0,
        WK_CART = 2'd1,
        WK_DRAM = 2'd2
    } win_kind_e;

    typedef struct packed {
        win_kind_e   kind;
        logic [1:0]  slot;
    } win_map_t;
endpackage

// File: rtl/srd_window_map.sv
module srd_window_map
    import srd_pkg::*;
#(
    parameter int WIN_IDX = 0
) (
    input  logic     map_on,
    input  logic     map_mode,
    output win_map_t wmap
);
    always_comb begin
        wmap.kind = WK_BOOT;
        wmap.slot = 2'd0;
        if (map_on) begin
            if (map_mode) begin
                if (WIN_IDX < HI_CART_FIRST) begin
                    wmap.kind = WK_DRAM;
                end else if (WIN_IDX < HI_CART_FIRST + CART_WINS) begin
                    wmap.kind = WK_CART;
                    wmap.slot = 2'(WIN_IDX - HI_CART_FIRST);
                end
            end else begin
                if (WIN_IDX >= LO_CART_FIRST && WIN_IDX < LO_CART_FIRST + CART_WINS) begin
                    wmap.kind = WK_CART;
                    wmap.slot = 2'(WIN_IDX - LO_CART_FIRST);
                end else if (WIN_IDX >= LO_CART_FIRST + CART_WINS) begin
                    wmap.kind = WK_DRAM;
                end
            end
        end
    end
endmodule

// File: rtl/srd_region_decode.sv
module srd_region_decode
    import srd_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int WIN_AW     = 21,
    parameter int BOOT_BYTES = 32'h20000,
    parameter int CART_BYTES = 32'h100000,
    parameter int DRAM_BYTES = 32'h200000,
    parameter int CTRL_SPAN  = 32'h400,
    parameter int LUT_SPAN   = 32'h400,
    parameter int LUT_IW     = 8
) (
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  win_map_t          wmap,
    output logic [REG_N-1:0]  sel,
    output logic [ADDR_W-1:0] mem_offset
);
    localparam int IO_W = WIN_AW - 1;
    localparam logic [ADDR_W-1:0] BOOT_MASK = ADDR_W'(BOOT_BYTES - 1);
    localparam logic [ADDR_W-1:0] CART_MASK = ADDR_W'(CART_BYTES - 1);
    localparam logic [ADDR_W-1:0] DRAM_MASK = ADDR_W'(DRAM_BYTES - 1);
    localparam logic [IO_W-1:0]   CTRL_END  = IO_W'(CTRL_SPAN);
    localparam logic [IO_W-1:0]   LUT_END   = IO_W'(CTRL_SPAN + LUT_SPAN);
    localparam logic [IO_W-1:0]   CTRL_MASK = IO_W'(CTRL_SPAN - 2);

    logic [WIN_AW-1:0] woff;
    logic [IO_W-1:0]   io_off;
    logic [ADDR_W-1:0] cart_base;
    int                hit;

    assign woff      = bus_addr[WIN_AW-1:0];
    assign io_off    = woff[IO_W-1:0];
    assign cart_base = ADDR_W'(wmap.slot) << WIN_AW;

    always_comb begin
        hit        = SEL_OTHER;
        mem_offset = '0;
        case (wmap.kind)
            WK_CART: begin
                hit        = SEL_CART;
                mem_offset = (cart_base | ADDR_W'(woff)) & CART_MASK;
            end
            WK_DRAM: begin
                hit        = SEL_DRAM;
                mem_offset = ADDR_W'(woff) & DRAM_MASK;
            end
            default: begin
                if (!woff[WIN_AW-1]) begin
                    hit        = SEL_BOOT;
                    mem_offset = bus_addr & BOOT_MASK;
                end else if (io_off < CTRL_END) begin
                    hit        = SEL_CTRL;
                    mem_offset = ADDR_W'(io_off & CTRL_MASK);
                end else if (io_off < LUT_END) begin
                    hit        = SEL_LUT;
                    mem_offset = ADDR_W'(io_off[LUT_IW:1]);
                end
            end
        endcase
    end

    always_comb begin
        sel      = '0;
        sel[hit] = bus_req;
    end
endmodule

// File: rtl/sysbus_remap_decoder.sv
module sysbus_remap_decoder
    import srd_pkg::*;
#(
    parameter int ADDR_W           = 24,
    parameter int DATA_W           = 16,
    parameter int BOOT_BYTES       = 32'h20000,
    parameter int CART_BYTES       = 32'h100000,
    parameter int CART_IMAGE_BYTES = 32'hC0000,
    parameter int DRAM_BYTES       = 32'h200000,
    parameter int LUT_N            = 256,
    parameter int CTRL_SPAN        = 32'h400,
    parameter int LUT_SPAN         = 32'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [REG_N-1:0]  sel,
    output logic [ADDR_W-1:0] mem_offset,
    output logic [DATA_W-1:0] rdata,
    output logic              unhandled,
    output logic [DATA_W-1:0] ctrl1,
    output logic [DATA_W-1:0] ctrl2
);
    localparam int WIN_SW   = $clog2(WIN_N);
    localparam int WIN_AW   = ADDR_W - WIN_SW;
    localparam int LUT_IW   = $clog2(LUT_N);
    localparam int CTRL_OW  = $clog2(CTRL_SPAN);
    localparam int CART_PAD = (CART_IMAGE_BYTES + 1) / 2 * 2;
    localparam logic [CTRL_OW-1:0] CTRL1_OFF = CTRL_OW'(0);
    localparam logic [CTRL_OW-1:0] CTRL2_OFF = CTRL_OW'(2);

    typedef struct packed {
        logic [DATA_W-1:0]            ctrl1;
        logic [DATA_W-1:0]            ctrl2;
        logic                         mapped;
        logic                         mode;
        logic [LUT_N-1:0][DATA_W-1:0] lut;
    } dec_state_t;

    dec_state_t st_d, st_q;

    win_map_t                win_tbl [WIN_N];
    win_map_t                cur_map;
    logic [CTRL_OW-1:0]      ctrl_off;
    logic [LUT_IW-1:0]       lut_idx;
    logic                    ctrl_ok;

    for (genvar w = 0; w < WIN_N; w++) begin : g_win
        srd_window_map #(.WIN_IDX(w)) u_win (
            .map_on   (st_q.mapped),
            .map_mode (st_q.mode),
            .wmap     (win_tbl[w])
        );
    end

    assign cur_map = win_tbl[bus_addr[ADDR_W-1:WIN_AW]];

    srd_region_decode #(
        .ADDR_W     (ADDR_W),
        .WIN_AW     (WIN_AW),
        .BOOT_BYTES (BOOT_BYTES),
        .CART_BYTES (CART_BYTES),
        .DRAM_BYTES (DRAM_BYTES),
        .CTRL_SPAN  (CTRL_SPAN),
        .LUT_SPAN   (LUT_SPAN),
        .LUT_IW     (LUT_IW)
    ) u_dec (
        .bus_req    (bus_req),
        .bus_addr   (bus_addr),
        .wmap       (cur_map),
        .sel        (sel),
        .mem_offset (mem_offset)
    );

    assign ctrl_off = mem_offset[CTRL_OW-1:0];
    assign lut_idx  = mem_offset[LUT_IW-1:0];
    assign ctrl_ok  = (ctrl_off == CTRL1_OFF) || (ctrl_off == CTRL2_OFF);

    always_comb begin
        st_d = st_q;
        if (bus_req && bus_we) begin
            if (sel[SEL_CTRL]) begin
                if (ctrl_off == CTRL1_OFF) begin
                    if (!st_q.mapped || (bus_wdata[0] != st_q.ctrl1[0])) begin
                        st_d.mapped = 1'b1;
                        st_d.mode   = bus_wdata[0];
                    end
                    st_d.ctrl1 = bus_wdata;
                end else if (ctrl_off == CTRL2_OFF) begin
                    st_d.ctrl2 = bus_wdata;
                end
            end
            if (sel[SEL_LUT]) begin
                st_d.lut[lut_idx] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel[SEL_LUT]) begin
            rdata = st_q.lut[lut_idx];
        end else if (sel[SEL_CART] && (mem_offset >= ADDR_W'(CART_PAD))) begin
            rdata = '1;
        end
    end

    assign unhandled = sel[SEL_OTHER] | (sel[SEL_CTRL] & (~bus_we | ~ctrl_ok));
    assign ctrl1     = st_q.ctrl1;
    assign ctrl2     = st_q.ctrl2;
endmodule

// File: rtl/srd_checker.sv
module srd_checker
    import srd_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 16,
    parameter int CART_PAD = 32'hC0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [REG_N-1:0]  sel,
    input logic [ADDR_W-1:0] mem_offset,
    input logic [DATA_W-1:0] rdata,
    input logic              unhandled,
    input logic [DATA_W-1:0] ctrl1,
    input logic [DATA_W-1:0] ctrl2
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ($countones(sel) == 1)); // R2
    AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (sel == '0 && !unhandled)); // R2
    AST_CTRL1_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && sel[SEL_CTRL] && mem_offset == '0) |=> (ctrl1 == $past(bus_wdata))); // R4
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_we && sel[SEL_CTRL]) |=> ($stable(ctrl1) && $stable(ctrl2))); // R12
    AST_OTHER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && sel[SEL_OTHER]) |-> unhandled); // R12
    AST_CART_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[SEL_CART] && mem_offset >= ADDR_W'(CART_PAD)) |-> (rdata == '1)); // R11
endmodule

bind sysbus_remap_decoder srd_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CART_PAD (CART_PAD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .sel        (sel),
    .mem_offset (mem_offset),
    .rdata      (rdata),
    .unhandled  (unhandled),
    .ctrl1      (ctrl1),
    .ctrl2      (ctrl2)
);

// File: tb/test_sysbus_remap_decoder.sv
module test_sysbus_remap_decoder;
    localparam int CLK_P = 10;
    localparam int unsigned BOOT = 32'h20000;
    localparam int unsigned CART = 32'h100000;
    localparam int unsigned IMG  = 32'hBFFFF;
    localparam int unsigned DRAM = 32'h200000;
    localparam int unsigned WIN  = 32'h200000;
    localparam int unsigned PAD  = (IMG + 1) / 2 * 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [5:0]  sel;
    logic [23:0] mem_offset;
    logic [15:0] rdata;
    logic        unhandled;
    logic [15:0] ctrl1, ctrl2;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // reference model state
    bit          m_mapped = 0;
    bit          m_mode = 0;
    logic [15:0] m_c1 = 0, m_c2 = 0;
    logic [15:0] m_lut [256];

    always #(CLK_P/2) clk = ~clk;

    sysbus_remap_decoder #(
        .BOOT_BYTES(BOOT), .CART_BYTES(CART), .CART_IMAGE_BYTES(IMG), .DRAM_BYTES(DRAM)
    ) i_sysbus_remap_decoder (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sel(sel),
        .mem_offset(mem_offset), .rdata(rdata), .unhandled(unhandled),
        .ctrl1(ctrl1), .ctrl2(ctrl2)
    );

    task automatic chk(input string tag, input string what, input int unsigned act, input int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // region codes: 0 boot 1 cart 2 dram 3 lut 4 ctrl 5 other
    task automatic acc(input bit rq, input bit w, input int unsigned a, input logic [15:0] d, input string t);
        int unsigned win, wo, io, off, rd, reg_i, slot;
        int          kind;
        bit          unh;
        string       mt, ot;
        @(negedge clk);
        bus_req = rq; bus_we = w; bus_addr = a[23:0]; bus_wdata = d;
        #2;
        win = a / WIN; wo = a % WIN; slot = 0;
        if (!m_mapped)   begin kind = 0; mt = "R1"; end
        else if (m_mode) begin mt = "R5";
            if (win < 4) kind = 2; else if (win < 7) begin kind = 1; slot = win - 4; end else kind = 0;
        end else begin mt = "R6";
            if (win == 0) kind = 0; else if (win < 4) begin kind = 1; slot = win - 1; end else kind = 2;
        end
        off = 0; rd = 0; unh = 0;
        if (kind == 1) begin reg_i = 1; off = (slot * WIN + wo) % CART; ot = "R8";
            if (off >= PAD) rd = 16'hFFFF;
        end else if (kind == 2) begin reg_i = 2; off = wo % DRAM; ot = "R9";
        end else if (wo < WIN / 2) begin reg_i = 0; off = a % BOOT; ot = "R1";
        end else begin
            io = wo - WIN / 2; ot = "R3";
            if (io < 32'h400) begin reg_i = 4; off = io & 32'h3FE;
                unh = !w || !(off == 0 || off == 2);
            end else if (io < 32'h800) begin reg_i = 3; off = (io / 2) % 256; rd = m_lut[off];
            end else begin reg_i = 5; unh = 1; end
        end
        if (t != "") mt = t;
        if (rq) begin
            chk(mt, "sel", sel, 1 << reg_i);
            chk(ot, "mem_offset", mem_offset, off);
            chk(reg_i == 3 ? "R10" : "R11", "rdata", rdata, rd);
            chk("R12", "unhandled", unhandled, unh);
        end else begin
            chk("R2", "idle sel", sel, 0);
            chk("R2", "idle unhandled", unhandled, 0);
        end
        chk("R4", "ctrl1", ctrl1, m_c1);
        chk("R4", "ctrl2", ctrl2, m_c2);
        if (rq && w) begin
            if (reg_i == 4 && off == 0) begin
                if (!m_mapped || ((d[0] ^ m_c1[0]) == 1'b1)) begin m_mapped = 1; m_mode = d[0]; end
                m_c1 = d;
            end else if (reg_i == 4 && off == 2) m_c2 = d;
            else if (reg_i == 3) m_lut[off] = d;
        end
    endtask

    task automatic sweep(input string t);
        for (int w = 0; w < 8; w++) begin
            acc(1, 0, w * WIN + 32'h2, 0, t);
            acc(1, 0, w * WIN + 32'hBFFFE, 0, t);
            acc(1, 0, w * WIN + 32'hC0000, 0, t);
            acc(1, 0, w * WIN + 32'h1FFFFE, 0, t);
            acc(1, 0, w * WIN + 32'h100402, 0, t);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) m_lut[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1", "reset ctrl1", ctrl1, 0);
        chk("R1", "reset ctrl2", ctrl2, 0);
        @(negedge clk); rst_n = 1'b1;
        // R1 boot everywhere and zeroed lookup table
        acc(1, 0, 32'h000010, 0, "R1");
        acc(1, 0, 32'h7A0002, 0, "R1");
        acc(1, 0, 32'h3FFFFE, 0, "R1");
        acc(1, 0, 32'h1007FE, 0, "R10");
        // R3 I/O ranges
        acc(1, 0, 32'h100000, 0, "R3");
        acc(1, 0, 32'h700004, 0, "R3");
        acc(1, 0, 32'h100800, 0, "R3");
        acc(1, 1, 32'h1FFFFE, 16'h1234, "R3");
        // R10 lookup table write and readback, incl. mirrored alias
        acc(1, 1, 32'h100400, 16'hA5A5, "R10");
        acc(1, 1, 32'h1007FE, 16'h5A5A, "R10");
        acc(1, 0, 32'h100400, 0, "R10");
        acc(1, 0, 32'h100600, 0, "R10");
        acc(1, 0, 32'h1007FE, 0, "R10");
        // R12 write to an unknown control offset, R4 ctrl2
        acc(1, 1, 32'h100004, 16'hFFFF, "R12");
        acc(1, 1, 32'h100002, 16'hBEEF, "R4");
        acc(1, 0, 32'h200000, 0, "R12");
        // R7 first write with bit0 = 0 activates layout 0
        acc(1, 1, 32'h100000, 16'h0000, "R7");
        acc(1, 0, 32'h200000, 0, "R7");
        sweep("R6");
        // R7 same bit0: value stored, map unchanged
        acc(1, 1, 32'h100000, 16'h0010, "R7");
        acc(1, 0, 32'h2C0000, 0, "R11");
        // R5 switch to layout 1
        acc(1, 1, 32'h100000, 16'h0011, "R7");
        sweep("R5");
        acc(1, 1, 32'hF00002, 16'h7777, "R4");
        acc(1, 1, 32'hF00000, 16'h0000, "R7");
        sweep("R6");
        // R2 idle cycles
        for (int i = 0; i < 4; i++) acc(0, 1, 32'h100000, 16'h0001, "R2");
        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            int unsigned a, r;
            r = $urandom;
            if (r[1:0] == 2'b00) a = (r[6:4] * WIN) + 32'h100000 + ($urandom & 32'h0FFE);
            else a = $urandom & 32'hFFFFFE;
            acc(1, r[3:2] == 2'b00, a, 16'($urandom), "");
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule